// File: doc/BRIEF.md
# Key Event Trace Capture Register

This block watches the key-on and key-off activity of an FM-synthesis emulation engine and keeps a sticky record of which channels saw an event. The engine has two banks of nine melodic channels each, plus five rhythm channels. Each clock cycle it may raise event strobes for any set of melodic channels in one bank (named by a bank input) and for any set of rhythm channels. Each strobe marks a key change, whether the key went on or off.

The host reads the record through a single 32-bit read-only word. A read strobe latches the word into a registered output and clears the flags it reported, so each event is seen once. The two melodic banks share one 9-bit field. A bank flag in the word tells the host which bank filled that field. Bank 0 takes precedence whenever it holds any pending flag. Bank 1 keeps its flags until a read reports it.

Top module: `key_trace_reg`

## Requirements
- R1: After synchronous reset the read data is 32'h0000_0000, and a read with no event since reset also returns 32'h0000_0000.
- R2: In a returned word, bit i (i = 0..8) is 1 exactly when melodic channel i of the reported bank had an event since that bank was last reported. Bit 15 names the reported bank: 0 for bank 0, 1 for bank 1.
- R3: In a returned word, bit 9+i (i = 0..4, so bits 13..9) is 1 exactly when rhythm channel i had an event since the last read.
- R4: Bit 14 and bits 31..16 of the read data are always 0.
- R5: A read clears the flags it reported. A second read with no events in between returns 0 in every reported bit.
- R6: When bank 0 has any pending flag, a read reports bank 0 (bit 15 = 0). Otherwise, if bank 1 has a pending flag, the read reports bank 1 (bit 15 = 1). Otherwise bit 15 is 0. The flags of the bank that was not reported are kept.
- R7: An event that arrives in the same cycle as a clearing read is not lost. Its flag is set after that read and appears in the next read.
- R8: Flags are sticky. Several events on one channel before a read give the same word as a single event.
- R9: The read data register loads only on the clock edge where the read strobe is high. It is valid from the following cycle and holds its value while the strobe stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mel_evt | input | 9 | Melodic channel event strobes, bit i = channel i |
| mel_bank | input | 1 | Bank of the melodic strobes this cycle (0 or 1) |
| rhy_evt | input | 5 | Rhythm channel event strobes, bit i = channel i |
| rd_stb | input | 1 | Read strobe; latches the word and clears reported flags |
| rd_data | output | 32 | Registered read word |

## Verification
The embedded assertions cover the properties that hold on every cycle:
- Reserved bits read as zero.
- The read register stays still without a strobe.
- An event strobe always leaves its flag set on the next edge.
- Flags never change without a set or a clear.
- A read clears bank 0 when it reports bank 0.
- Bank 0 wins the shared field whenever it has a pending flag.

Only the directed scenarios can show the cross-cycle meaning of the record:
- Exact bit positions of melodic and rhythm flags.
- Bank 1 flags survive a bank 0 report and appear on the following read.
- An event colliding with a read shows up one read later.
- Repeated events collapse into one flag.

// File: rtl/kt_pkg.sv
package kt_pkg;
  localparam int WORD_W = 32;

  typedef enum logic {
    BANK_LO = 1'b0,
    BANK_HI = 1'b1
  } bank_e;
endpackage

// File: rtl/kt_flag_bank.sv
module kt_flag_bank #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_i,
  input  logic [W-1:0] set_i,
  output logic [W-1:0] flags_o
);
  logic [W-1:0] flags_q;

  // a clear and a set in one cycle: the set wins for its own bits
  always_ff @(posedge clk) begin
    if (rst) flags_q <= '0;
    else     flags_q <= (clr_i ? '0 : flags_q) | set_i;
  end

  assign flags_o = flags_q;

  // R7 R8
  set_sticks_chk: assert property (@(posedge clk) disable iff (rst)
    (set_i != '0) |=> ((flags_q & $past(set_i)) == $past(set_i)));

  // R5
  idle_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && set_i == '0) |=> $stable(flags_q));
endmodule

// File: rtl/kt_read_mux.sv
module kt_read_mux
  import kt_pkg::*;
#(
  parameter int MEL_CH = 9,
  parameter int RHY_CH = 5
) (
  input  logic [MEL_CH-1:0] bank0_i,
  input  logic [MEL_CH-1:0] bank1_i,
  input  logic [RHY_CH-1:0] rhy_i,
  output bank_e             sel_o,
  output logic [WORD_W-1:0] word_o
);
  localparam int RHY_LSB  = MEL_CH;
  localparam int BANK_BIT = RHY_LSB + RHY_CH + 1;

  always_comb begin
    if (bank0_i == '0 && bank1_i != '0) sel_o = BANK_HI;
    else                                sel_o = BANK_LO;
  end

  always_comb begin
    word_o = '0;
    word_o[MEL_CH-1:0]        = (sel_o == BANK_HI) ? bank1_i : bank0_i;
    word_o[RHY_LSB +: RHY_CH] = rhy_i;
    word_o[BANK_BIT]          = (sel_o == BANK_HI);
  end

  // R6
  bank0_first_chk: assert final ((bank0_i == '0) || (sel_o == BANK_LO));
endmodule

// File: rtl/key_trace_reg.sv
module key_trace_reg
  import kt_pkg::*;
#(
  parameter int MEL_CH = 9,
  parameter int RHY_CH = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MEL_CH-1:0] mel_evt,
  input  logic              mel_bank,
  input  logic [RHY_CH-1:0] rhy_evt,
  input  logic              rd_stb,
  output logic [31:0]       rd_data
);
  localparam int N_BANKS  = 2;
  localparam int RHY_LSB  = MEL_CH;
  localparam int BANK_BIT = RHY_LSB + RHY_CH + 1;

  logic [MEL_CH-1:0] mel_flags [N_BANKS];
  logic [RHY_CH-1:0] rhy_flags;
  bank_e             sel;
  logic [WORD_W-1:0] word;

  for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
    logic [MEL_CH-1:0] bank_set;
    logic              bank_clr;

    assign bank_set = (mel_bank == b[0]) ? mel_evt : '0;
    assign bank_clr = rd_stb && (sel == bank_e'(b[0]));

    kt_flag_bank #(.W(MEL_CH)) u_bank (
      .clk     (clk),
      .rst     (rst),
      .clr_i   (bank_clr),
      .set_i   (bank_set),
      .flags_o (mel_flags[b])
    );
  end

  kt_flag_bank #(.W(RHY_CH)) u_rhy (
    .clk     (clk),
    .rst     (rst),
    .clr_i   (rd_stb),
    .set_i   (rhy_evt),
    .flags_o (rhy_flags)
  );

  kt_read_mux #(.MEL_CH(MEL_CH), .RHY_CH(RHY_CH)) u_mux (
    .bank0_i (mel_flags[0]),
    .bank1_i (mel_flags[1]),
    .rhy_i   (rhy_flags),
    .sel_o   (sel),
    .word_o  (word)
  );

  always_ff @(posedge clk) begin
    if (rst)         rd_data <= '0;
    else if (rd_stb) rd_data <= word;
  end

  // R4
  reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_data[31:BANK_BIT+1] == '0) && (rd_data[BANK_BIT-1] == 1'b0));

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_stb |=> $stable(rd_data));

  // R6
  bank0_report_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && mel_flags[0] != '0) |=> (rd_data[BANK_BIT] == 1'b0));

  // R5
  clear_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && sel == BANK_LO && mel_evt == '0) |=> (mel_flags[0] == '0));
endmodule

// File: tb/key_trace_reg_bench.sv
module key_trace_reg_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic [8:0]  mel_evt;
  logic        mel_bank;
  logic [4:0]  rhy_evt;
  logic        rd_stb;
  logic [31:0] rd_data;

  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  key_trace_reg u_key_trace_reg (
    .clk      (clk),
    .rst      (rst),
    .mel_evt  (mel_evt),
    .mel_bank (mel_bank),
    .rhy_evt  (rhy_evt),
    .rd_stb   (rd_stb),
    .rd_data  (rd_data)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic pulse(input logic bank, input logic [8:0] m, input logic [4:0] r);
    mel_bank = bank; mel_evt = m; rhy_evt = r;
    @(negedge clk);
    mel_evt = '0; rhy_evt = '0;
  endtask

  task automatic do_read(output logic [31:0] w);
    rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
    w = rd_data;
  endtask

  task automatic t_reset();
    logic [31:0] w;
    check("R1 reset value", rd_data, 32'h0);
    do_read(w);
    check("R1 empty read", w, 32'h0);
  endtask

  task automatic t_melodic();
    logic [31:0] w;
    pulse(1'b0, 9'h101, 5'h0);
    do_read(w);
    check("R2 bank0 ch0/ch8", w, 32'h0000_0101);
    do_read(w);
    check("R5 cleared after read", w, 32'h0);
  endtask

  task automatic t_rhythm();
    logic [31:0] w;
    pulse(1'b0, 9'h0, 5'b10001);
    do_read(w);
    check("R3 rhythm ch0/ch4", w, 32'h0000_2200);
    check("R4 reserved bits", w & 32'hFFFF_4000, 32'h0);
    do_read(w);
    check("R5 rhythm cleared", w, 32'h0);
  endtask

  task automatic t_priority();
    logic [31:0] w;
    pulse(1'b1, 9'h0AA, 5'h0);
    pulse(1'b0, 9'h003, 5'h0);
    do_read(w);
    check("R6 bank0 first", w, 32'h0000_0003);
    do_read(w);
    check("R6 bank1 kept and reported", w, 32'h0000_80AA);
    do_read(w);
    check("R5 both banks cleared", w, 32'h0);
  endtask

  task automatic t_overlap();
    logic [31:0] w;
    pulse(1'b0, 9'h010, 5'h0);
    mel_bank = 1'b0; mel_evt = 9'h004; rhy_evt = 5'h02; rd_stb = 1'b1;
    @(negedge clk);
    mel_evt = '0; rhy_evt = '0; rd_stb = 1'b0;
    check("R7 read during event", rd_data, 32'h0000_0010);
    do_read(w);
    check("R7 colliding event kept", w, 32'h0000_0404);
  endtask

  task automatic t_sticky();
    logic [31:0] w;
    for (int i = 0; i < 3; i++) pulse(1'b0, 9'h008, 5'h0);
    do_read(w);
    check("R8 repeated events", w, 32'h0000_0008);
  endtask

  task automatic t_hold();
    logic [31:0] w;
    pulse(1'b1, 9'h100, 5'h01);
    do_read(w);
    check("R9 read loads", w, 32'h0000_8300);
    pulse(1'b0, 9'h1FF, 5'h1F);
    @(negedge clk);
    check("R9 hold without strobe", rd_data, 32'h0000_8300);
    do_read(w);
    check("R2 all bank0 and rhythm", w, 32'h0000_3FFF);
  endtask

  initial begin
    rst = 1'b1; mel_evt = '0; mel_bank = 1'b0; rhy_evt = '0; rd_stb = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_melodic();
    t_rhythm();
    t_priority();
    t_overlap();
    t_sticky();
    t_hold();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule